// File: doc/BRIEF.md
# DMA Channel Control and Buffer Switching

This block is the control half of one DMA channel. Software programs it through a small register port: a peripheral request selector, a burst type for each side of the transfer, a priority level, a double-buffer enable, a buffer selector, and two memory base addresses. The data mover, bus master, arbitration between channels and interrupt logic are outside the block. They read its outputs: the base address of the memory region in use, the beat count of each burst, and the selected request line and priority.

The configuration is frozen while the channel enable input is high. Only the priority and the two base addresses stay writable. This lets software refill the idle buffer while the other one is being transferred. When FIFO mode is off, an enabled channel has both burst types forced to single transfers, and the stored fields are cleared. In double-buffer mode, each transfer-complete pulse flips the buffer selector, so the active base address alternates between the two regions.

Top module: `dma_chan_ctl`

## Requirements
- R1: After a synchronous reset, every register reads 0, active_base is 0, cur_buf is 0, and both beat counts are 1.
- R2: The control register (address 0) holds these fields: request select in bits 27:25, memory burst in bits 24:23, peripheral burst in bits 22:21, buffer select in bit 19, switch enable in bit 18 and priority in bits 17:16. A write while the channel is disabled reads back one cycle later and drives req_sel and prio.
- R3: While chan_en is 1, a control write leaves the request select, both burst fields, the buffer select and the switch enable unchanged, and it still updates the priority.
- R4: Each burst code gives a beat count on its side: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16.
- R5: When chan_en is 1 and fifo_mode is 0, both beat counts are 1 in the same cycle and both burst fields read 00. After one such clock edge the stored burst fields stay 00 once the channel is disabled again.
- R6: Bit 20 of the control register always reads 0, whatever is written to it.
- R7: Base registers sit at address 1 (region 0) and address 2 (region 1) and can be written at any time. active_base equals the region 0 base when cur_buf is 0 and the region 1 base when cur_buf is 1.
- R8: A xfer_done pulse with chan_en at 1 and the switch enable at 1 inverts cur_buf and bit 19 one cycle later, and active_base follows.
- R9: A xfer_done pulse with the switch enable at 0, or with chan_en at 0, leaves cur_buf unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Read data (combinational) |
| chan_en | input | 1 | Channel enable |
| fifo_mode | input | 1 | FIFO (multi-data) mode enable |
| xfer_done | input | 1 | Single-cycle transfer-complete pulse |
| active_base | output | 32 | Base address of the active memory region |
| cur_buf | output | 1 | Active memory buffer index |
| mem_beats | output | 5 | Effective memory burst beat count |
| per_beats | output | 5 | Effective peripheral burst beat count |
| req_sel | output | 3 | Selected peripheral request line |
| prio | output | 2 | Priority level |

## Verification
A register write or a xfer_done pulse changes state at the next rising edge. Readback, cur_buf, active_base and the beat counts therefore take effect one edge after the stimulus. The checks drive on a falling edge and sample on the following falling edge, exactly one edge later. The burst lock from chan_en and fifo_mode acts without a register. Its beat counts are checked half a cycle after the inputs change, before any edge, to show that the forcing is immediate. The stored-field clearing is then checked after the channel is disabled.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int REG_W      = 32;
    localparam int RA_W       = 2;
    localparam int BEAT_W     = 5;
    localparam int NUM_BUF    = 2;

    localparam logic [RA_W-1:0] CTRL_ADDR  = 2'd0;
    localparam logic [RA_W-1:0] BASE0_ADDR = 2'd1;
    localparam logic [RA_W-1:0] BASE1_ADDR = 2'd2;

    localparam int REQ_LSB  = 25;
    localparam int MB_LSB   = 23;
    localparam int PB_LSB   = 21;
    localparam int RSV_BIT  = 20;
    localparam int BUF_BIT  = 19;
    localparam int SW_BIT   = 18;
    localparam int PRI_LSB  = 16;

    typedef enum logic [1:0] {
        BURST_SINGLE = 2'b00,
        BURST_INC4   = 2'b01,
        BURST_INC8   = 2'b10,
        BURST_INC16  = 2'b11
    } burst_e;

    typedef struct packed {
        logic [2:0] req_sel;
        burst_e     mem_burst;
        burst_e     per_burst;
        logic       sw_en;
        logic [1:0] prio;
    } ctrl_t;

    function automatic logic [BEAT_W-1:0] burst_beats(burst_e b);
        logic [2:0] sh;
        sh = (b == BURST_SINGLE) ? 3'd0 : {1'b0, b} + 3'd1;
        return BEAT_W'(1) << sh;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_t c, logic buf_sel);
        logic [REG_W-1:0] r;
        r = '0;
        r[REQ_LSB +: 3] = c.req_sel;
        r[MB_LSB  +: 2] = c.mem_burst;
        r[PB_LSB  +: 2] = c.per_burst;
        r[BUF_BIT]      = buf_sel;
        r[SW_BIT]       = c.sw_en;
        r[PRI_LSB +: 2] = c.prio;
        return r;
    endfunction
endpackage

// File: rtl/dmac_cfg_regs.sv
module dmac_cfg_regs
    import dmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wr_data,
    input  logic             chan_en,
    input  logic             fifo_mode,
    output ctrl_t            ctrl_eff
);
    ctrl_t ctrl_q;
    logic  burst_lock;

    assign burst_lock = chan_en && !fifo_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.prio <= wr_data[PRI_LSB +: 2];
                if (!chan_en) begin
                    ctrl_q.req_sel   <= wr_data[REQ_LSB +: 3];
                    ctrl_q.mem_burst <= burst_e'(wr_data[MB_LSB +: 2]);
                    ctrl_q.per_burst <= burst_e'(wr_data[PB_LSB +: 2]);
                    ctrl_q.sw_en     <= wr_data[SW_BIT];
                end
            end
            if (burst_lock) begin
                ctrl_q.mem_burst <= BURST_SINGLE;
                ctrl_q.per_burst <= BURST_SINGLE;
            end
        end
    end

    always_comb begin
        ctrl_eff = ctrl_q;
        if (burst_lock) begin
            ctrl_eff.mem_burst = BURST_SINGLE;
            ctrl_eff.per_burst = BURST_SINGLE;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        chan_en |=> ($stable(ctrl_q.req_sel) && $stable(ctrl_q.sw_en))); // R3

    AST_BURST_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !fifo_mode) |=> (ctrl_q.mem_burst == BURST_SINGLE && ctrl_q.per_burst == BURST_SINGLE)); // R5
endmodule

// File: rtl/dmac_buf_sel.sv
module dmac_buf_sel (
    input  logic clk,
    input  logic rst,
    input  logic chan_en,
    input  logic sw_en,
    input  logic xfer_done,
    input  logic wr_ctrl,
    input  logic wr_buf,
    output logic buf_q
);
    logic hw_flip;

    assign hw_flip = chan_en && sw_en && xfer_done;

    always_ff @(posedge clk) begin
        if (rst)                      buf_q <= 1'b0;
        else if (hw_flip)             buf_q <= ~buf_q;
        else if (wr_ctrl && !chan_en) buf_q <= wr_buf;
    end

    AST_BUF_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (chan_en && sw_en && xfer_done) |=> (buf_q != $past(buf_q))); // R8

    AST_BUF_HELD: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !(sw_en && xfer_done)) |=> $stable(buf_q)); // R9
endmodule

// File: rtl/dmac_burst_map.sv
module dmac_burst_map
    import dmac_pkg::*;
(
    input  burst_e              burst,
    output logic [BEAT_W-1:0]   beats
);
    assign beats = burst_beats(burst);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [RA_W-1:0]    wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [RA_W-1:0]    rd_addr,
    output logic [REG_W-1:0]   rd_data,
    input  logic               chan_en,
    input  logic               fifo_mode,
    input  logic               xfer_done,
    output logic [ADDR_W-1:0]  active_base,
    output logic               cur_buf,
    output logic [BEAT_W-1:0]  mem_beats,
    output logic [BEAT_W-1:0]  per_beats,
    output logic [2:0]         req_sel,
    output logic [1:0]         prio
);
    ctrl_t             ctrl;
    logic              wr_ctrl;
    logic [ADDR_W-1:0] base_q [NUM_BUF];

    assign wr_ctrl = wr_en && (wr_addr == CTRL_ADDR);

    dmac_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wr_data   (wr_data),
        .chan_en   (chan_en),
        .fifo_mode (fifo_mode),
        .ctrl_eff  (ctrl)
    );

    dmac_buf_sel u_buf (
        .clk       (clk),
        .rst       (rst),
        .chan_en   (chan_en),
        .sw_en     (ctrl.sw_en),
        .xfer_done (xfer_done),
        .wr_ctrl   (wr_ctrl),
        .wr_buf    (wr_data[BUF_BIT]),
        .buf_q     (cur_buf)
    );

    dmac_burst_map u_mem_map (.burst(ctrl.mem_burst), .beats(mem_beats));
    dmac_burst_map u_per_map (.burst(ctrl.per_burst), .beats(per_beats));

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_base
        localparam logic [RA_W-1:0] MY_ADDR = BASE0_ADDR + RA_W'(g);
        always_ff @(posedge clk) begin
            if (rst)                               base_q[g] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)  base_q[g] <= wr_data[ADDR_W-1:0];
        end
    end

    assign active_base = base_q[cur_buf];
    assign req_sel     = ctrl.req_sel;
    assign prio        = ctrl.prio;

    always_comb begin
        unique case (rd_addr)
            CTRL_ADDR:  rd_data = pack_ctrl(ctrl, cur_buf);
            BASE0_ADDR: rd_data = REG_W'(base_q[0]);
            BASE1_ADDR: rd_data = REG_W'(base_q[1]);
            default:    rd_data = '0;
        endcase
    end

    AST_LOCK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !fifo_mode) |-> (mem_beats == BEAT_W'(1) && per_beats == BEAT_W'(1))); // R5

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == CTRL_ADDR) |-> !rd_data[RSV_BIT]); // R6

    AST_BASE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (chan_en && ctrl.sw_en && xfer_done) |=> (active_base == base_q[~$past(cur_buf)])); // R8
endmodule

// File: tb/dma_chan_ctl_bench.sv
module dma_chan_ctl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic        chan_en, fifo_mode, xfer_done;
    logic [31:0] active_base;
    logic        cur_buf;
    logic [4:0]  mem_beats, per_beats;
    logic [2:0]  req_sel;
    logic [1:0]  prio;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dma_chan_ctl u_dma_chan_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .chan_en(chan_en), .fifo_mode(fifo_mode),
        .xfer_done(xfer_done), .active_base(active_base), .cur_buf(cur_buf),
        .mem_beats(mem_beats), .per_beats(per_beats), .req_sel(req_sel), .prio(prio)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] beats_of(int code);
        return (code == 0) ? 5'd1 : 5'd2 << code;
    endfunction

    function automatic logic [31:0] ctrl_word(int rq, int mb, int pb, int bs, int sw, int pr);
        return (32'(rq) << 25) | (32'(mb) << 23) | (32'(pb) << 21) |
               (32'(bs) << 19) | (32'(sw) << 18) | (32'(pr) << 16);
    endfunction

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        chan_en = 0; fifo_mode = 0; xfer_done = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 3; a++) begin
            rd_addr = 2'(a); #1;
            chk("R1 reg", rd_data, 32'h0);
        end
        chk("R1 base", active_base, 0);
        chk("R1 buf", 32'(cur_buf), 0);
        chk("R1 mbeats", 32'(mem_beats), 1);
        chk("R1 pbeats", 32'(per_beats), 1);
        rd_addr = 0;

        // R2 R4 R6 sweep of burst codes, request select and priority
        for (int mb = 0; mb < 4; mb++) begin
            for (int pb = 0; pb < 4; pb++) begin
                int rq = (mb * 4 + pb) % 8;
                int pr = (mb + pb) % 4;
                wr(2'd0, ctrl_word(rq, mb, pb, 0, 0, pr) | 32'h0010_0000);
                rd_addr = 0; #1;
                chk("R2 R6 readback", rd_data, ctrl_word(rq, mb, pb, 0, 0, pr));
                chk("R2 req_sel", 32'(req_sel), 32'(rq));
                chk("R2 prio", 32'(prio), 32'(pr));
                chk("R4 mem beats", 32'(mem_beats), 32'(beats_of(mb)));
                chk("R4 per beats", 32'(per_beats), 32'(beats_of(pb)));
                // enabled with FIFO mode on: bursts kept
                fifo_mode = 1; chan_en = 1; #1;
                chk("R4 fifo mem beats", 32'(mem_beats), 32'(beats_of(mb)));
                // FIFO mode off: immediate forcing
                fifo_mode = 0; #1;
                chk("R5 mem single", 32'(mem_beats), 1);
                chk("R5 per single", 32'(per_beats), 1);
                @(negedge clk);
                chan_en = 0; fifo_mode = 1; #1;
                chk("R5 cleared", rd_data & 32'h01E0_0000, 0);
                fifo_mode = 0;
            end
        end

        // R3 frozen fields while enabled
        wr(2'd0, ctrl_word(5, 2, 1, 0, 1, 0));
        chan_en = 1; fifo_mode = 1;
        wr(2'd0, ctrl_word(2, 1, 3, 1, 0, 3));
        #1;
        chk("R3 frozen", rd_data, ctrl_word(5, 2, 1, 0, 1, 3));
        chk("R3 prio", 32'(prio), 3);
        chan_en = 0;
        @(negedge clk);

        // R7 base registers and selection
        wr(2'd1, 32'hA000_1000);
        wr(2'd2, 32'hB000_2000);
        rd_addr = 1; #1; chk("R7 base0 read", rd_data, 32'hA000_1000);
        rd_addr = 2; #1; chk("R7 base1 read", rd_data, 32'hB000_2000);
        rd_addr = 0;
        chk("R7 active0", active_base, 32'hA000_1000);
        wr(2'd0, ctrl_word(0, 0, 0, 1, 0, 0));
        chk("R7 active1", active_base, 32'hB000_2000);
        chk("R7 buf1", 32'(cur_buf), 1);

        // R9 done with switch off, enabled
        chan_en = 1;
        pulse_done();
        chk("R9 sw off", 32'(cur_buf), 1);
        chan_en = 0;
        // enable switch mode, buffer 0
        wr(2'd0, ctrl_word(0, 0, 0, 0, 1, 0));
        pulse_done();
        chk("R9 chan off", 32'(cur_buf), 0);

        // R8 toggling sequence, with base update while enabled
        chan_en = 1; fifo_mode = 1;
        for (int k = 1; k <= 6; k++) begin
            pulse_done();
            #1;
            chk("R8 buf", 32'(cur_buf), 32'(k % 2));
            chk("R8 bit19", 32'(rd_data[19]), 32'(k % 2));
            chk("R8 base", active_base, (k % 2) ? 32'hB000_2000 : 32'hA000_1000);
        end
        wr(2'd1, 32'hC000_3000);
        chk("R7 base write while enabled", active_base, 32'hC000_3000);
        chan_en = 0;

        // R1 reset again clears everything
        rst = 1; @(negedge clk); rst = 0; #1;
        chk("R1 rereset ctrl", rd_data, 0);
        chk("R1 rereset base", active_base, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule